// File: doc/BRIEF.md
# DMA channel status, abort and interrupt controller

This block keeps the per-channel control state of a multi-channel DMA engine. It does not move any data. It holds one enable bit per channel and accepts channel abort requests and a global software reset through a simple register port. It also records four per-channel event flags: half-complete, terminal count, abort and error. The channel engines report their events on three pulse vectors. The block sends abort pulses back to the engines and drives a single combined interrupt line.

Software starts channels by writing ones to an enable-set register and can read the enable vector back at any time. An abort or a software reset stops channels. Engine events can also stop them: a finished transfer or an error clears the channel's enable. Flags stay set until software clears them. Per-channel masks decide which flags reach the interrupt line, and they never change the flags themselves.

Top module: `dma_irq_ctrl`

## Requirements
- R1: After a synchronous active-high reset, every enable, flag and mask bit reads 0 and the interrupt output is 0.
- R2: A write to address 2 sets the enable of every channel whose data bit is 1, and address 3 reads back the enable vector in the next cycle.
- R3: A write to address 1 aborts only those channels whose data bit is 1 and that are enabled. For those channels, abort_pulse is high during the write, the enable bit clears and the abort flag (address 6) sets at the same clock edge. Data bits for disabled channels have no effect.
- R4: A write to address 0 with data bit 0 set clears all channel enables and leaves all flags and masks unchanged.
- R5: A done pulse on an enabled channel sets its terminal-count flag (address 5) only if neither an error pulse nor an abort hits that channel in the same cycle. A done pulse on an enabled channel also clears the channel's enable.
- R6: An error pulse on an enabled channel sets its error flag (address 7) and clears its enable.
- R7: Half, done and error pulses on channels that are not enabled change no flag and no enable.
- R8: Writing 1 to a bit of address 5, 6 or 7 clears that flag, and writing 0 leaves it unchanged. A write to address 4 loads the half-complete flags directly.
- R9: When a flag set event and a clearing write reach the same bit in the same cycle, the flag ends up set.
- R10: Addresses 8 to 11 hold the masks for half, terminal count, abort and error, in that order. irq is high exactly when some flag bit is 1 and its mask bit is 0. Masks do not change the flags.
- R11: Reads of addresses 0, 1, 2 and 12 to 15 return 0.
- R12: A half pulse on an enabled channel sets its half-complete flag (address 4) and leaves the channel enabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register address for both read and write |
| reg_wdata | input | DATA_W | Write data |
| reg_rdata | output | DATA_W | Read data for reg_addr (combinational) |
| evt_half | input | NUM_CH | Half-complete pulses from the engines |
| evt_done | input | NUM_CH | Transfer-finished pulses from the engines |
| evt_err | input | NUM_CH | Error pulses from the engines |
| abort_pulse | output | NUM_CH | Abort command to the engines for the channels being aborted |
| irq | output | 1 | Combined interrupt |

## Verification
The hardest cases to reach are same-cycle collisions. One is a done pulse that meets an abort or an error on the same channel. Another is a clearing write that lands on a bit while an event is setting it. Directed steps produce each of these once on purpose. A long random run follows, with sparse event vectors, a heavily mixed write address and a high enable-set rate, so the collisions recur many times. The run is compared every cycle against a behavioural model that is written only from the requirements.

// File: rtl/dmaic_pkg.sv
package dmaic_pkg;

    localparam int unsigned ADDR_W    = 4;
    localparam int unsigned NUM_KINDS = 4;

    localparam int unsigned KIND_HALF = 0;
    localparam int unsigned KIND_TC   = 1;
    localparam int unsigned KIND_ABT  = 2;
    localparam int unsigned KIND_ERR  = 3;

    typedef enum logic [ADDR_W-1:0] {
        A_SWRST    = 4'd0,
        A_ABORT    = 4'd1,
        A_EN_SET   = 4'd2,
        A_EN_VIEW  = 4'd3,
        A_ST_HALF  = 4'd4,
        A_ST_TC    = 4'd5,
        A_ST_ABT   = 4'd6,
        A_ST_ERR   = 4'd7,
        A_MSK_HALF = 4'd8,
        A_MSK_TC   = 4'd9,
        A_MSK_ABT  = 4'd10,
        A_MSK_ERR  = 4'd11
    } reg_sel_e;

    typedef enum logic {
        ST_LOAD = 1'b0,
        ST_W1C  = 1'b1
    } st_mode_e;

    typedef struct packed {
        logic                 swrst;
        logic                 abort;
        logic                 en_set;
        logic [NUM_KINDS-1:0] st_wr;
        logic [NUM_KINDS-1:0] msk_wr;
    } wr_strobe_t;

    function automatic wr_strobe_t decode_write(input logic we,
                                                input logic [ADDR_W-1:0] addr,
                                                input logic bit0);
        wr_strobe_t s;
        s.swrst  = we && (addr == A_SWRST) && bit0;
        s.abort  = we && (addr == A_ABORT);
        s.en_set = we && (addr == A_EN_SET);
        for (int k = 0; k < NUM_KINDS; k++) begin
            s.st_wr[k]  = we && (int'(addr) == int'(A_ST_HALF) + k);
            s.msk_wr[k] = we && (int'(addr) == int'(A_MSK_HALF) + k);
        end
        return s;
    endfunction

    function automatic st_mode_e kind_mode(input int k);
        return (k == int'(KIND_HALF)) ? ST_LOAD : ST_W1C;
    endfunction

endpackage

// File: rtl/dmaic_enable.sv
module dmaic_enable
    import dmaic_pkg::*;
#(
    parameter int unsigned NUM_CH = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  wr_strobe_t        strb,
    input  logic [NUM_CH-1:0] wdata,
    input  logic [NUM_CH-1:0] evt_done,
    input  logic [NUM_CH-1:0] evt_err,
    output logic [NUM_CH-1:0] en_q,
    output logic [NUM_CH-1:0] abort_hit
);
    logic [NUM_CH-1:0] finish;
    logic [NUM_CH-1:0] set_req;
    logic [NUM_CH-1:0] en_d;

    always_comb begin
        abort_hit = strb.abort  ? (wdata & en_q) : '0;
        set_req   = strb.en_set ? wdata : '0;
        finish    = (evt_done | evt_err) & en_q;
        en_d      = (en_q | set_req) & ~abort_hit & ~finish;
        if (strb.swrst) en_d = '0;
    end

    always_ff @(posedge clk) begin
        if (rst) en_q <= '0;
        else     en_q <= en_d;
    end
endmodule

// File: rtl/dmaic_status.sv
module dmaic_status
    import dmaic_pkg::*;
#(
    parameter int unsigned NUM_CH = 32,
    parameter st_mode_e    MODE   = ST_W1C
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr,
    input  logic [NUM_CH-1:0] wdata,
    input  logic [NUM_CH-1:0] set,
    output logic [NUM_CH-1:0] st_q
);
    logic [NUM_CH-1:0] kept;

    generate
        if (MODE == ST_W1C) begin : g_w1c
            assign kept = wr ? (st_q & ~wdata) : st_q;
        end else begin : g_load
            assign kept = wr ? wdata : st_q;
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= kept | set;
    end
endmodule

// File: rtl/dmaic_irq.sv
module dmaic_irq
    import dmaic_pkg::*;
#(
    parameter int unsigned NUM_CH = 32
) (
    input  logic                             clk,
    input  logic                             rst,
    input  logic [NUM_KINDS-1:0]             msk_wr,
    input  logic [NUM_CH-1:0]                wdata,
    input  logic [NUM_KINDS-1:0][NUM_CH-1:0] st,
    output logic [NUM_KINDS-1:0][NUM_CH-1:0] msk_q,
    output logic                             irq
);
    logic [NUM_KINDS-1:0] kind_hit;

    for (genvar k = 0; k < NUM_KINDS; k++) begin : g_kind
        always_ff @(posedge clk) begin
            if (rst)            msk_q[k] <= '0;
            else if (msk_wr[k]) msk_q[k] <= wdata;
        end
        assign kind_hit[k] = |(st[k] & ~msk_q[k]);
    end

    assign irq = |kind_hit;
endmodule

// File: rtl/dma_irq_ctrl.sv
module dma_irq_ctrl
    import dmaic_pkg::*;
#(
    parameter int unsigned NUM_CH = 32,
    parameter int unsigned DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_we,
    input  logic [3:0]        reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    input  logic [NUM_CH-1:0] evt_half,
    input  logic [NUM_CH-1:0] evt_done,
    input  logic [NUM_CH-1:0] evt_err,
    output logic [NUM_CH-1:0] abort_pulse,
    output logic              irq
);
    wr_strobe_t                       strb;
    logic [NUM_CH-1:0]                wd_ch;
    logic [NUM_CH-1:0]                en_q;
    logic [NUM_CH-1:0]                abort_hit;
    logic [NUM_KINDS-1:0][NUM_CH-1:0] st_set;
    logic [NUM_KINDS-1:0][NUM_CH-1:0] st_q;
    logic [NUM_KINDS-1:0][NUM_CH-1:0] msk_q;

    assign strb  = decode_write(reg_we, reg_addr, reg_wdata[0]);
    assign wd_ch = reg_wdata[NUM_CH-1:0];

    dmaic_enable #(.NUM_CH(NUM_CH)) u_en (
        .clk      (clk),
        .rst      (rst),
        .strb     (strb),
        .wdata    (wd_ch),
        .evt_done (evt_done),
        .evt_err  (evt_err),
        .en_q     (en_q),
        .abort_hit(abort_hit)
    );

    assign abort_pulse = abort_hit;

    // flag set events; only live channels report
    always_comb begin
        st_set[KIND_HALF] = evt_half & en_q;
        st_set[KIND_TC]   = evt_done & ~evt_err & ~abort_hit & en_q;
        st_set[KIND_ABT]  = abort_hit;
        st_set[KIND_ERR]  = evt_err & en_q;
    end

    for (genvar k = 0; k < NUM_KINDS; k++) begin : g_st
        dmaic_status #(.NUM_CH(NUM_CH), .MODE(kind_mode(k))) u_st (
            .clk  (clk),
            .rst  (rst),
            .wr   (strb.st_wr[k]),
            .wdata(wd_ch),
            .set  (st_set[k]),
            .st_q (st_q[k])
        );
    end

    dmaic_irq #(.NUM_CH(NUM_CH)) u_irq (
        .clk   (clk),
        .rst   (rst),
        .msk_wr(strb.msk_wr),
        .wdata (wd_ch),
        .st    (st_q),
        .msk_q (msk_q),
        .irq   (irq)
    );

    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            A_EN_VIEW:  reg_rdata[NUM_CH-1:0] = en_q;
            A_ST_HALF:  reg_rdata[NUM_CH-1:0] = st_q[KIND_HALF];
            A_ST_TC:    reg_rdata[NUM_CH-1:0] = st_q[KIND_TC];
            A_ST_ABT:   reg_rdata[NUM_CH-1:0] = st_q[KIND_ABT];
            A_ST_ERR:   reg_rdata[NUM_CH-1:0] = st_q[KIND_ERR];
            A_MSK_HALF: reg_rdata[NUM_CH-1:0] = msk_q[KIND_HALF];
            A_MSK_TC:   reg_rdata[NUM_CH-1:0] = msk_q[KIND_TC];
            A_MSK_ABT:  reg_rdata[NUM_CH-1:0] = msk_q[KIND_ABT];
            A_MSK_ERR:  reg_rdata[NUM_CH-1:0] = msk_q[KIND_ERR];
            default:    reg_rdata = '0;
        endcase
    end
endmodule

// File: rtl/dmaic_checker.sv
module dmaic_checker #(
    parameter int unsigned NUM_CH = 32,
    parameter int unsigned DATA_W = 32
) (
    input logic              clk,
    input logic              rst,
    input logic              reg_we,
    input logic [3:0]        reg_addr,
    input logic [DATA_W-1:0] reg_wdata,
    input logic [NUM_CH-1:0] evt_err,
    input logic [NUM_CH-1:0] abort_pulse,
    input logic              irq,
    input logic [NUM_CH-1:0] en_vec,
    input logic [NUM_CH-1:0] half_vec,
    input logic [NUM_CH-1:0] tc_vec,
    input logic [NUM_CH-1:0] ab_vec,
    input logic [NUM_CH-1:0] er_vec
);
    AST_ABORT_ONLY_ENABLED: assert property (@(posedge clk) disable iff (rst)
        (abort_pulse & ~en_vec) == '0); // R3
    AST_ABORT_CLEARS_EN: assert property (@(posedge clk) disable iff (rst)
        (|abort_pulse) |=> ((en_vec & $past(abort_pulse)) == '0)); // R3
    AST_ABORT_FLAG_SET: assert property (@(posedge clk) disable iff (rst)
        (|abort_pulse) |=> ((ab_vec & $past(abort_pulse)) == $past(abort_pulse))); // R3
    AST_SWRST_STOPS_ALL: assert property (@(posedge clk) disable iff (rst)
        (reg_we && reg_addr == 4'd0 && reg_wdata[0]) |=> (en_vec == '0)); // R4
    AST_TC_CLEAN_END: assert property (@(posedge clk) disable iff (rst)
        ((tc_vec & ~$past(tc_vec)) & $past(evt_err | abort_pulse)) == '0); // R5
    AST_ERR_NEEDS_EN: assert property (@(posedge clk) disable iff (rst)
        ((er_vec & ~$past(er_vec)) & ~$past(en_vec)) == '0); // R7
    AST_IRQ_QUIET: assert property (@(posedge clk) disable iff (rst)
        ((half_vec | tc_vec | ab_vec | er_vec) == '0) |-> !irq); // R10
endmodule

bind dma_irq_ctrl dmaic_checker #(.NUM_CH(NUM_CH), .DATA_W(DATA_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .reg_we     (reg_we),
    .reg_addr   (reg_addr),
    .reg_wdata  (reg_wdata),
    .evt_err    (evt_err),
    .abort_pulse(abort_pulse),
    .irq        (irq),
    .en_vec     (en_q),
    .half_vec   (st_q[0]),
    .tc_vec     (st_q[1]),
    .ab_vec     (st_q[2]),
    .er_vec     (st_q[3])
);

// File: tb/tb_dma_irq_ctrl.sv
module tb_dma_irq_ctrl;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_we = 1'b0;
    logic [3:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic [31:0] evt_half = '0, evt_done = '0, evt_err = '0;
    logic [31:0] abort_pulse;
    logic        irq;

    int checks = 0;
    int errors = 0;
    bit done_flag = 0;

    // behavioural model state
    logic [31:0] m_en = '0, m_half = '0, m_tc = '0, m_ab = '0, m_er = '0;
    logic [31:0] m_mask [4] = '{default: '0};

    always #(CLK_PERIOD/2) clk = ~clk;

    dma_irq_ctrl dut (
        .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .evt_half(evt_half),
        .evt_done(evt_done), .evt_err(evt_err), .abort_pulse(abort_pulse), .irq(irq)
    );

    function automatic logic [31:0] model_read(input logic [3:0] a);
        case (a)
            4'd3:  return m_en;
            4'd4:  return m_half;
            4'd5:  return m_tc;
            4'd6:  return m_ab;
            4'd7:  return m_er;
            4'd8, 4'd9, 4'd10, 4'd11: return m_mask[a - 4'd8];
            default: return 32'h0;
        endcase
    endfunction

    function automatic string tag_of(input logic [3:0] a);
        case (a)
            4'd3:  return "R2";
            4'd4:  return "R8";
            4'd5:  return "R5";
            4'd6:  return "R3";
            4'd7:  return "R6";
            4'd8, 4'd9, 4'd10, 4'd11: return "R10";
            default: return "R11";
        endcase
    endfunction

    task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%08h expected=%08h at %0t", tag, what, act, exp, $time);
        end
    endtask

    task automatic step(input logic we, input logic [3:0] a, input logic [31:0] wd,
                        input logic [31:0] h, input logic [31:0] d, input logic [31:0] e,
                        input string tag);
        logic [31:0] hit, fin, tcset, en_n;
        logic        exp_irq;
        @(negedge clk);
        reg_we = we; reg_addr = a; reg_wdata = wd;
        evt_half = h; evt_done = d; evt_err = e;
        #1;
        exp_irq = |((m_half & ~m_mask[0]) | (m_tc & ~m_mask[1]) |
                    (m_ab & ~m_mask[2]) | (m_er & ~m_mask[3]));
        chk(tag == "" ? tag_of(a) : tag, "rdata", reg_rdata, model_read(a));
        chk("R10", "irq", {31'd0, irq}, {31'd0, exp_irq});
        hit = (we && a == 4'd1) ? (wd & m_en) : 32'h0;
        chk("R3", "abort_pulse", abort_pulse, hit);
        @(posedge clk);
        fin   = (d | e) & m_en;
        tcset = d & ~e & ~hit & m_en;
        en_n  = (m_en | ((we && a == 4'd2) ? wd : 32'h0)) & ~hit & ~fin;
        if (we && a == 4'd0 && wd[0]) en_n = 32'h0;
        m_half = ((we && a == 4'd4) ? wd : m_half) | (h & m_en);
        m_tc   = (m_tc & ~((we && a == 4'd5) ? wd : 32'h0)) | tcset;
        m_ab   = (m_ab & ~((we && a == 4'd6) ? wd : 32'h0)) | hit;
        m_er   = (m_er & ~((we && a == 4'd7) ? wd : 32'h0)) | (e & m_en);
        for (int k = 0; k < 4; k++)
            if (we && a == 4'(8 + k)) m_mask[k] = wd;
        m_en = en_n;
    endtask

    task automatic finish_run();
        if (!done_flag) begin
            done_flag = 1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        errors++;
        $display("FAIL watchdog R1 actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        // R1: reset state
        step(0, 4'd3, 0, 0, 0, 0, "R1");
        step(0, 4'd7, 0, 0, 0, 0, "R1");
        step(0, 4'd9, 0, 0, 0, 0, "R1");
        // R2: enable channels 0..7
        step(1, 4'd2, 32'h0000_00FF, 0, 0, 0, "R2");
        step(0, 4'd3, 0, 0, 0, 0, "R2");
        // R12: half on live ch0 and dead ch9
        step(0, 4'd4, 0, 32'h0000_0201, 0, 0, "R12");
        step(0, 4'd4, 0, 0, 0, 0, "R12");
        step(0, 4'd3, 0, 0, 0, 0, "R12");
        // R7: error and done on disabled ch9
        step(0, 4'd7, 0, 0, 32'h0000_0200, 32'h0000_0200, "R7");
        step(0, 4'd7, 0, 0, 0, 0, "R7");
        step(0, 4'd5, 0, 0, 0, 0, "R7");
        // R5: done with error on ch3 -> no terminal count; clean done on ch4
        step(0, 4'd5, 0, 0, 32'h0000_0018, 32'h0000_0008, "R5");
        step(0, 4'd5, 0, 0, 0, 0, "R5");
        step(0, 4'd7, 0, 0, 0, 0, "R6");
        // R5: done colliding with abort on ch5
        step(1, 4'd1, 32'h0000_0020, 0, 32'h0000_0020, 0, "R5");
        step(0, 4'd5, 0, 0, 0, 0, "R5");
        // R9: done on ch1 while clearing its terminal-count bit
        step(1, 4'd5, 32'h0000_0012, 0, 32'h0000_0002, 0, "R9");
        step(0, 4'd5, 0, 0, 0, 0, "R9");
        // R3: abort live ch2 and dead ch8
        step(1, 4'd1, 32'h0000_0104, 0, 0, 0, "R3");
        step(0, 4'd6, 0, 0, 0, 0, "R3");
        step(0, 4'd3, 0, 0, 0, 0, "R3");
        // R8: clear abort flags, load half flags
        step(1, 4'd6, 32'hFFFF_FFFF, 0, 0, 0, "R8");
        step(1, 4'd4, 32'hA000_0000, 0, 0, 0, "R8");
        step(0, 4'd4, 0, 0, 0, 0, "R8");
        // R10: mask everything, flags must stay
        for (int k = 0; k < 4; k++) step(1, 4'(8 + k), 32'hFFFF_FFFF, 0, 0, 0, "R10");
        step(0, 4'd4, 0, 0, 0, 0, "R10");
        for (int k = 0; k < 4; k++) step(1, 4'(8 + k), 32'h0, 0, 0, 0, "R10");
        // R4: software reset keeps flags
        step(1, 4'd2, 32'hFFFF_FFFF, 0, 0, 0, "R2");
        step(1, 4'd0, 32'h0000_0001, 0, 0, 0, "R4");
        step(0, 4'd3, 0, 0, 0, 0, "R4");
        step(0, 4'd4, 0, 0, 0, 0, "R4");
        // R11: write-only and unmapped reads
        step(0, 4'd0, 0, 0, 0, 0, "R11");
        step(0, 4'd1, 0, 0, 0, 0, "R11");
        step(0, 4'd2, 0, 0, 0, 0, "R11");
        step(0, 4'd14, 0, 0, 0, 0, "R11");
        // random mixed traffic with collisions
        for (int i = 0; i < 4000; i++) begin
            logic [3:0]  a;
            logic        w;
            a = 4'($urandom_range(0, 15));
            if ($urandom_range(0, 3) == 0) a = 4'd2;
            w = ($urandom_range(0, 3) != 0);
            step(w, a, $urandom, $urandom & $urandom & $urandom,
                 $urandom & $urandom & $urandom, $urandom & $urandom & $urandom & $urandom, "");
        end
        finish_run();
    end
endmodule